// File: doc/BRIEF.md
# Serial-Bus Peripheral Interrupt and DMA Arbiter

This block decides, every clock cycle, which request of a serial-bus peripheral is served. It keeps five pending bits: one for the error event and four for the data sources. The four data sources are data-received, receive end-of-block, ready-to-transmit and transmit end-of-block. It also takes two DMA service requests, one for receive and one for transmit. From the pending bits, their masks, a global interrupt enable and the DMA requests, it produces a single grant code. It also drives one request line per interrupt vector and a DMA-suspend signal.

The error pending bit is forced by a group of error flags and stays set for as long as any flag is high. A DMA-stop control bit selects the relative rank of DMA and the error interrupt. With the bit at 0, DMA outranks every interrupt. With the bit at 1, DMA ranks below the error interrupt and is suspended while the error pending bit is set. The end-of-block sources share a vector and a priority level with their data sources. A status output shows whether the end-of-block source is the one asserting each shared vector.

Top module: `sbus_irq_dma_arb`

## Requirements
- R1: After reset the four source pending bits and the error pending bit are 0, the DMA-stop bit is 1, `grant` is 0 and `dma_suspend` is 0.
- R2: If any bit of `err_flags` is high at a clock edge, `err_pend` is 1 after that edge. `clr_err` has no effect at an edge where any flag is high. With all flags low, `clr_err` clears `err_pend` at the next edge, and without it `err_pend` keeps its value.
- R3: Pending bit order in `pend`, `evt`, `clr_pend` and `src_mask` is 0 = data-received, 1 = receive end-of-block, 2 = ready-to-transmit, 3 = transmit end-of-block. An `evt` bit sets its pending bit at the next edge. A `clr_pend` bit clears it. Otherwise the bit holds, so a bit left set keeps requesting.
- R4: When an `evt` bit and the matching `clr_pend` bit are high at the same edge, the pending bit is 1 after it.
- R5: With the DMA-stop bit at 0, an enabled DMA request (`dma_req[i] & dma_en[i]`, index 0 = receive, 1 = transmit) wins over every interrupt source. Receive DMA wins over transmit DMA.
- R6: With the DMA-stop bit at 1 and `err_pend` at 1, `dma_suspend` is 1 and no DMA grant is given, even when the error interrupt is masked.
- R7: With the DMA-stop bit at 1, the grant order is: error interrupt, receive DMA, transmit DMA, receive vector, transmit vector.
- R8: `irq_rx` is high when data-received is pending and enabled, or when receive end-of-block is pending and masked in. `rx_via_eob` is high when receive end-of-block is pending and masked in. `irq_tx` and `tx_via_eob` work the same way for bits 2 and 3.
- R9: `glob_ie` gates the error, data-received and ready-to-transmit interrupts, but not the two end-of-block interrupts.
- R10: A write pulse `stop_we` loads `stop_wdata` into the DMA-stop bit at the next edge, which `dma_stop` shows.
- R11: `grant` codes are 0 none, 1 error, 2 receive DMA, 3 transmit DMA, 4 receive vector, 5 transmit vector. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_flags | input | NUM_ERR | Error condition flags that force the error pending bit |
| evt | input | 4 | Event strobes that set the source pending bits |
| clr_pend | input | 4 | Software clears of the source pending bits |
| clr_err | input | 1 | Software clear of the error pending bit |
| src_mask | input | 4 | Per-source interrupt mask, 1 = enabled |
| err_mask | input | 1 | Error interrupt mask, 1 = enabled |
| glob_ie | input | 1 | Global enable for the error and data interrupts |
| dma_req | input | 2 | DMA service requests (0 receive, 1 transmit) |
| dma_en | input | 2 | DMA enables (0 receive, 1 transmit) |
| stop_we | input | 1 | Write strobe for the DMA-stop bit |
| stop_wdata | input | 1 | Value written into the DMA-stop bit |
| pend | output | 4 | Source pending bits |
| err_pend | output | 1 | Error pending bit |
| dma_stop | output | 1 | Current DMA-stop bit |
| grant | output | 3 | Granted request code |
| irq_err | output | 1 | Error vector request |
| irq_rx | output | 1 | Receive vector request |
| irq_tx | output | 1 | Transmit vector request |
| rx_via_eob | output | 1 | Receive vector is asserted by end-of-block |
| tx_via_eob | output | 1 | Transmit vector is asserted by end-of-block |
| dma_suspend | output | 1 | DMA held off by a pending error |

## Verification
The bench targets several corner cases, each with a known failure.
- A clear and a set of the same pending bit in one cycle. A design with clear priority would lose the event.
- A software clear of the error bit while a flag is still high. A design that obeys it would drop an active error.
- An error that is pending but masked, with the DMA-stop bit at 1. A design that suspends on the masked request instead of the pending bit would grant DMA.
- The global enable low with only end-of-block pending. A design that gates those sources would leave the shared vector silent.
- Random mixes that toggle the DMA-stop bit. A design with one fixed order would place DMA on the wrong side of the error interrupt.

// File: rtl/sbus_arb_pkg.sv
`timescale 1ns/1ps
package sbus_arb_pkg;

   typedef enum logic [2:0] {
      GNT_NONE = 3'd0,
      GNT_ERR  = 3'd1,
      GNT_DRX  = 3'd2,
      GNT_DTX  = 3'd3,
      GNT_VRX  = 3'd4,
      GNT_VTX  = 3'd5
   } grant_e;

   localparam int SRC_RXD  = 0;
   localparam int SRC_REOB = 1;
   localparam int SRC_TXR  = 2;
   localparam int SRC_TEOB = 3;
   localparam int NUM_SRC  = 4;

endpackage

// File: rtl/sbus_arb_pend_bank.sv
`timescale 1ns/1ps
// Bank of sticky pending bits; a hardware set beats a software clear.
module sbus_arb_pend_bank #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("sbus_arb_pend_bank: WIDTH must be at least 1");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else if (set_i[gi]) bit_q <= 1'b1;
            else if (clr_i[gi]) bit_q <= 1'b0;
         end
         assign q_o[gi] = bit_q;
      end
   endgenerate

endmodule

// File: rtl/sbus_arb_err_latch.sv
`timescale 1ns/1ps
// Error pending bit, forced by any error flag; the clear works only with all flags low.
module sbus_arb_err_latch #(
   parameter int NUM_ERR   = 9,
   parameter bit COMB_PASS = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_ERR-1:0] flags_i,
   input  logic               clr_i,
   output logic               pend_o
);

   generate
      if (NUM_ERR < 1) begin : g_bad_num
         $error("sbus_arb_err_latch: NUM_ERR must be at least 1");
      end
   endgenerate

   logic any_flag;
   logic pend_q;

   assign any_flag = |flags_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else if (any_flag) pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
   end

   generate
      if (COMB_PASS) begin : g_pass
         assign pend_o = pend_q | any_flag;
      end else begin : g_reg
         assign pend_o = pend_q;
      end
   endgenerate

endmodule

// File: rtl/sbus_arb_prio.sv
`timescale 1ns/1ps
// Fixed-priority select; DMA ranks above or below the error source per stop bit.
module sbus_arb_prio
   import sbus_arb_pkg::*;
#(
   parameter bit DMA_RX_FIRST = 1'b1
) (
   input  logic   dma_stop_i,
   input  logic   err_req_i,
   input  logic   drx_req_i,
   input  logic   dtx_req_i,
   input  logic   vrx_req_i,
   input  logic   vtx_req_i,
   output grant_e grant_o
);

   logic   dma_a, dma_b;
   grant_e code_a, code_b;

   generate
      if (DMA_RX_FIRST) begin : g_rx_first
         assign dma_a  = drx_req_i;
         assign dma_b  = dtx_req_i;
         assign code_a = GNT_DRX;
         assign code_b = GNT_DTX;
      end else begin : g_tx_first
         assign dma_a  = dtx_req_i;
         assign dma_b  = drx_req_i;
         assign code_a = GNT_DTX;
         assign code_b = GNT_DRX;
      end
   endgenerate

   logic   dma_hit;
   grant_e dma_code;

   assign dma_hit  = dma_a | dma_b;
   assign dma_code = dma_a ? code_a : code_b;

   always_comb begin
      if (!dma_stop_i && dma_hit) grant_o = dma_code;
      else if (err_req_i)         grant_o = GNT_ERR;
      else if (dma_hit)           grant_o = dma_code;
      else if (vrx_req_i)         grant_o = GNT_VRX;
      else if (vtx_req_i)         grant_o = GNT_VTX;
      else                        grant_o = GNT_NONE;
   end

endmodule

// File: rtl/sbus_irq_dma_arb.sv
`timescale 1ns/1ps
module sbus_irq_dma_arb
   import sbus_arb_pkg::*;
#(
   parameter int NUM_ERR      = 9,
   parameter bit DMA_RX_FIRST = 1'b1,
   parameter bit ERR_COMB     = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_ERR-1:0] err_flags,
   input  logic [3:0]         evt,
   input  logic [3:0]         clr_pend,
   input  logic               clr_err,
   input  logic [3:0]         src_mask,
   input  logic               err_mask,
   input  logic               glob_ie,
   input  logic [1:0]         dma_req,
   input  logic [1:0]         dma_en,
   input  logic               stop_we,
   input  logic               stop_wdata,
   output logic [3:0]         pend,
   output logic               err_pend,
   output logic               dma_stop,
   output logic [2:0]         grant,
   output logic               irq_err,
   output logic               irq_rx,
   output logic               irq_tx,
   output logic               rx_via_eob,
   output logic               tx_via_eob,
   output logic               dma_suspend
);

   localparam int NSRC = NUM_SRC;

   generate
      if (NUM_ERR < 1 || NUM_ERR > 32) begin : g_bad_err
         $error("sbus_irq_dma_arb: NUM_ERR out of range");
      end
   endgenerate

   // DMA-stop control bit, reset to 1
   logic stop_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stop_q <= 1'b1;
      else if (stop_we) stop_q <= stop_wdata;
   end
   assign dma_stop = stop_q;

   logic [NSRC-1:0] pend_w;
   sbus_arb_pend_bank #(.WIDTH(NSRC)) i_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt),
      .clr_i (clr_pend),
      .q_o   (pend_w)
   );
   assign pend = pend_w;

   logic err_w;
   sbus_arb_err_latch #(.NUM_ERR(NUM_ERR), .COMB_PASS(ERR_COMB)) i_err (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (err_flags),
      .clr_i   (clr_err),
      .pend_o  (err_w)
   );
   assign err_pend = err_w;

   // per-source request terms; the global enable skips the end-of-block pair
   logic [NSRC-1:0] src_gate;
   logic [NSRC-1:0] src_req;
   assign src_gate[SRC_RXD]  = glob_ie;
   assign src_gate[SRC_REOB] = 1'b1;
   assign src_gate[SRC_TXR]  = glob_ie;
   assign src_gate[SRC_TEOB] = 1'b1;
   assign src_req = pend_w & src_mask & src_gate;

   assign irq_err    = err_w & err_mask & glob_ie;
   assign irq_rx     = src_req[SRC_RXD] | src_req[SRC_REOB];
   assign irq_tx     = src_req[SRC_TXR] | src_req[SRC_TEOB];
   assign rx_via_eob = src_req[SRC_REOB];
   assign tx_via_eob = src_req[SRC_TEOB];

   assign dma_suspend = stop_q & err_w;

   logic [1:0] dma_live;
   assign dma_live = dma_req & dma_en & {2{~dma_suspend}};

   grant_e grant_w;
   sbus_arb_prio #(.DMA_RX_FIRST(DMA_RX_FIRST)) i_prio (
      .dma_stop_i (stop_q),
      .err_req_i  (irq_err),
      .drx_req_i  (dma_live[0]),
      .dtx_req_i  (dma_live[1]),
      .vrx_req_i  (irq_rx),
      .vtx_req_i  (irq_tx),
      .grant_o    (grant_w)
   );
   assign grant = grant_w;

endmodule

// File: rtl/sbus_arb_chk.sv
`timescale 1ns/1ps
module sbus_arb_chk #(
   parameter int NUM_ERR = 9
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_ERR-1:0] err_flags,
   input logic [3:0]         evt,
   input logic               clr_err,
   input logic [1:0]         dma_req,
   input logic [1:0]         dma_en,
   input logic [3:0]         pend,
   input logic               err_pend,
   input logic               dma_stop,
   input logic [2:0]         grant,
   input logic               irq_err,
   input logic               dma_suspend
);

   a_r2_flag_forces_err: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_flags) |=> err_pend);

   a_r2_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (err_pend && !clr_err) |=> err_pend);

   a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != 4'd0) |=> ((pend & $past(evt)) == $past(evt)));

   a_r5_dma_on_top: assert property (@(posedge clk) disable iff (!rst_n)
      (!dma_stop && ((dma_req & dma_en) != 2'd0)) |-> (grant == 3'd2 || grant == 3'd3));

   a_r6_dma_held: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_stop && err_pend) |-> (dma_suspend && grant != 3'd2 && grant != 3'd3));

   a_r7_err_first: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_stop && irq_err) |-> (grant == 3'd1));

   a_r11_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      grant <= 3'd5);

endmodule

bind sbus_irq_dma_arb sbus_arb_chk #(.NUM_ERR(NUM_ERR)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .err_flags   (err_flags),
   .evt         (evt),
   .clr_err     (clr_err),
   .dma_req     (dma_req),
   .dma_en      (dma_en),
   .pend        (pend),
   .err_pend    (err_pend),
   .dma_stop    (dma_stop),
   .grant       (grant),
   .irq_err     (irq_err),
   .dma_suspend (dma_suspend)
);

// File: tb/test_sbus_irq_dma_arb.sv
`timescale 1ns/1ps
module test_sbus_irq_dma_arb;

   localparam int NE = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NE-1:0] err_flags = '0;
   logic [3:0]    evt = '0, clr_pend = '0, src_mask = '0;
   logic          clr_err = 1'b0, err_mask = 1'b0, glob_ie = 1'b0;
   logic [1:0]    dma_req = '0, dma_en = '0;
   logic          stop_we = 1'b0, stop_wdata = 1'b0;
   logic [3:0]    pend;
   logic          err_pend, dma_stop, irq_err, irq_rx, irq_tx;
   logic          rx_via_eob, tx_via_eob, dma_suspend;
   logic [2:0]    grant;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // bench model state
   logic [3:0] m_pend = '0;
   logic       m_err = 1'b0;
   logic       m_stop = 1'b1;

   always #2.5 clk = ~clk;

   sbus_irq_dma_arb #(.NUM_ERR(NE)) i_sbus_irq_dma_arb (
      .clk(clk), .rst_n(rst_n), .err_flags(err_flags), .evt(evt),
      .clr_pend(clr_pend), .clr_err(clr_err), .src_mask(src_mask),
      .err_mask(err_mask), .glob_ie(glob_ie), .dma_req(dma_req),
      .dma_en(dma_en), .stop_we(stop_we), .stop_wdata(stop_wdata),
      .pend(pend), .err_pend(err_pend), .dma_stop(dma_stop), .grant(grant),
      .irq_err(irq_err), .irq_rx(irq_rx), .irq_tx(irq_tx),
      .rx_via_eob(rx_via_eob), .tx_via_eob(tx_via_eob),
      .dma_suspend(dma_suspend)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [2:0] exp_grant(input logic stop, input logic e,
                                            input logic drx, input logic dtx,
                                            input logic vrx, input logic vtx);
      if (!stop && drx) return 3'd2;
      if (!stop && dtx) return 3'd3;
      if (e)   return 3'd1;
      if (drx) return 3'd2;
      if (dtx) return 3'd3;
      if (vrx) return 3'd4;
      if (vtx) return 3'd5;
      return 3'd0;
   endfunction

   task automatic model_edge();
      if (!rst_n) begin
         m_pend = '0; m_err = 1'b0; m_stop = 1'b1;
      end else begin
         for (int i = 0; i < 4; i++)
            if (evt[i]) m_pend[i] = 1'b1;
            else if (clr_pend[i]) m_pend[i] = 1'b0;
         if (|err_flags) m_err = 1'b1;
         else if (clr_err) m_err = 1'b0;
         if (stop_we) m_stop = stop_wdata;
      end
   endtask

   task automatic compare_all();
      logic e_ierr, e_rxe, e_txe, e_rx, e_tx, e_susp, drx, dtx;
      e_ierr = m_err & err_mask & glob_ie;
      e_rxe  = m_pend[1] & src_mask[1];
      e_txe  = m_pend[3] & src_mask[3];
      e_rx   = (m_pend[0] & src_mask[0] & glob_ie) | e_rxe;
      e_tx   = (m_pend[2] & src_mask[2] & glob_ie) | e_txe;
      e_susp = m_stop & m_err;
      drx    = dma_req[0] & dma_en[0] & ~e_susp;
      dtx    = dma_req[1] & dma_en[1] & ~e_susp;
      check("R3 pend", pend, m_pend);
      check("R2 err_pend", err_pend, m_err);
      check("R10 dma_stop", dma_stop, m_stop);
      check("R6 dma_suspend", dma_suspend, e_susp);
      check("R9 irq_err", irq_err, e_ierr);
      check("R8 irq_rx", irq_rx, e_rx);
      check("R8 irq_tx", irq_tx, e_tx);
      check("R8 eob status", {rx_via_eob, tx_via_eob}, {e_rxe, e_txe});
      check(m_stop ? "R7 grant" : "R5 grant", grant,
            exp_grant(m_stop, e_ierr, drx, dtx, e_rx, e_tx));
   endtask

   task automatic step();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle_inputs();
      err_flags = '0; evt = '0; clr_pend = '0; clr_err = 1'b0;
      stop_we = 1'b0; stop_wdata = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20250611));
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1: reset state
      check("R1 pend after reset", pend, 0);
      check("R1 err_pend after reset", err_pend, 0);
      check("R1 dma_stop after reset", dma_stop, 1);
      check("R1 grant after reset", grant, 0);
      check("R1 dma_suspend after reset", dma_suspend, 0);

      // R4: set and clear together on every source bit
      evt = 4'hF; clr_pend = 4'hF;
      step();
      idle_inputs();
      check("R4 set beats clear", pend, 4'hF);
      clr_pend = 4'hF; step(); idle_inputs();
      check("R3 clear all", pend, 0);

      // R2: clear ignored while a flag is high
      err_flags = 9'h100; clr_err = 1'b1; step();
      check("R2 forced by flag", err_pend, 1);
      err_flags = 9'h004; step();
      check("R2 clear ignored with flag", err_pend, 1);
      idle_inputs(); step();
      check("R2 held without clear", err_pend, 1);
      clr_err = 1'b1; step(); idle_inputs();
      check("R2 cleared with flags low", err_pend, 0);

      // R6: masked error still suspends DMA when stop=1
      err_flags = 9'h001; step(); idle_inputs();
      dma_req = 2'b11; dma_en = 2'b11; err_mask = 1'b0; glob_ie = 1'b1;
      step();
      check("R6 suspend with masked error", dma_suspend, 1);
      check("R6 no DMA grant", grant, 0);

      // R5: stop=0 puts DMA above an enabled error
      err_mask = 1'b1; stop_we = 1'b1; stop_wdata = 1'b0; step(); idle_inputs();
      check("R10 stop written", dma_stop, 0);
      check("R5 rx DMA over error", grant, 2);
      dma_en = 2'b10; step();
      check("R5 tx DMA over error", grant, 3);
      clr_err = 1'b1; dma_req = 2'b00; step(); idle_inputs();

      // R9: global enable off, only end-of-block raises the vectors
      glob_ie = 1'b0; src_mask = 4'hF; evt = 4'b1010; step(); idle_inputs();
      check("R9 rx eob not gated", irq_rx, 1);
      check("R9 tx eob status", tx_via_eob, 1);
      check("R7 rx vector first", grant, 4);
      clr_pend = 4'hF; evt = 4'b0101; step(); idle_inputs();
      check("R9 data sources gated", {irq_rx, irq_tx}, 0);
      clr_pend = 4'hF; step(); idle_inputs();

      // random mixture
      for (int c = 0; c < 4000; c++) begin
         err_flags = ($urandom % 10 == 0) ? NE'(1 << ($urandom % NE)) : '0;
         evt       = 4'($urandom) & 4'($urandom);
         clr_pend  = 4'($urandom);
         clr_err   = ($urandom % 3 == 0);
         src_mask  = 4'($urandom);
         err_mask  = ($urandom % 4 != 0);
         glob_ie   = ($urandom % 4 != 0);
         dma_req   = 2'($urandom);
         dma_en    = 2'($urandom);
         stop_we   = ($urandom % 16 == 0);
         stop_wdata = 1'($urandom);
         step();
      end

      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule